// File: doc/BRIEF.md
# Synchronous Serial Slave Shift Unit with Selectable Clock Phase

This block is the bit-level engine of a serial peripheral slave. It takes an external shift clock, an active-high frame select and a serial data input, and it drives one serial data output. It shifts a parallel transmit word out most significant bit first and assembles the incoming bits into a received word. Every input is sampled by the system clock. The shift clock, the select and the data input each pass through a two-stage synchronizer, and edges are detected on the synchronized copies. The shift clock idles low, so its rising edge is the leading edge and its falling edge is the trailing edge.

Two clock phase modes are supported. In leading-launch mode (`phase_i` = 0) the slave drives a bit on each leading edge and captures a bit on each trailing edge. In select-launch mode (`phase_i` = 1) the first bit appears as soon as the select rises. Each later bit is driven on a trailing edge, and every bit is captured on a leading edge.

Each word may carry an optional parity bit after its data bits, and either even or odd parity can be chosen. A word that completes produces a one-cycle valid strobe. In the same cycle the next transmit word is taken from `tx_word_i`, so a frame can hold several words back to back. A parity mismatch and a select activation each raise a one-cycle event, and each event has its own enable. If the select drops in the middle of a word, that word is abandoned.

Top module: `spi_phase_slave`

## Requirements
- R1: With `phase_i` = 0, a bit is driven on `sdo_o` after each leading (rising) shift clock edge while select is high. Bits go out most significant first, and the output holds until the next leading edge.
- R2: With `phase_i` = 0, `sdi_i` is captured on each trailing (falling) edge. The word completes on the trailing edge of its last bit.
- R3: With `phase_i` = 1, the most significant bit of the word loaded at select activation appears on `sdo_o` after the select rises, before any shift clock edge.
- R4: With `phase_i` = 1, the bits after the first are driven after trailing edges, and every bit is captured on a leading edge.
- R5: `word_len_i` gives the number of data bits, from 1 to MAX_W. The received word is right-aligned in `rx_word_o`, and its upper bits are zero.
- R6: When `par_en_i` = 1, one parity bit follows the data bits in both directions. With `par_odd_i` = 0 the data plus parity hold an even number of ones; with `par_odd_i` = 1 they hold an odd number.
- R7: A received parity mismatch pulses `par_err_o` in the same cycle as `rx_valid_o`, but only when `par_ie_i` = 1.
- R8: A rising edge of the select pulses `sel_evt_o` for one cycle, but only when `sel_ie_i` = 1.
- R9: If the select falls before a word's last bit, no valid strobe is produced for that word. The next frame starts again from its first bit.
- R10: `rx_valid_o` lasts one system clock. In that same cycle `tx_word_i` is loaded as the next word to transmit.
- R11: After reset, `sdo_o`, `rx_word_o`, `rx_valid_o`, `par_err_o` and `sel_evt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | External shift clock, idles low |
| sel_i | input | 1 | External frame select, active high |
| sdi_i | input | 1 | Serial data in |
| phase_i | input | 1 | 0: leading-edge launch, 1: select launch |
| word_len_i | input | LW | Data bits per word, 1 to MAX_W |
| par_en_i | input | 1 | Append and check a parity bit |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| par_ie_i | input | 1 | Enables the parity error event |
| sel_ie_i | input | 1 | Enables the select activation event |
| tx_word_i | input | MAX_W | Next word to transmit, right-aligned |
| sdo_o | output | 1 | Serial data out |
| rx_word_o | output | MAX_W | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |
| par_err_o | output | 1 | One-cycle parity error event |
| sel_evt_o | output | 1 | One-cycle select activation event |

## Verification
The bench acts as the master and checks every bit the slave drives at the last moment before that bit may legally change. A slave that launched on the wrong edge, or that in select-launch mode missed the first bit at select rise, would show a shifted or stale bit in that window. Word lengths of 1 and 16 are included, together with frames of up to three words, which catch a slave that miscounts the boundary or fails to reload the transmit word at a strobe. Corrupted parity bits are sent with the event enabled and with it disabled, so an ungated event or a flipped parity sense is reported. A select dropped in the middle of a word, followed by a fresh frame, shows whether a slave wrongly strobes a partial word or carries a stale bit count into the next frame.

// File: rtl/spis_pkg.sv
// Package: shared types and helpers for the serial slave shift unit.
// Assumes: nothing beyond IEEE 1800-2017.
package spis_pkg;

    // Clock phase modes selected by phase_i.
    typedef enum logic {
        PH_LEAD_LAUNCH = 1'b0,   // drive on leading edge, capture on trailing
        PH_SEL_LAUNCH  = 1'b1    // first bit on select rise, capture on leading
    } phase_e;

endpackage

// File: rtl/spis_sync.sv
// Module: spis_sync
// Brings a vector of asynchronous single-bit inputs into the system clock
// domain through STAGES flops per bit.
// Assumes: each bit is an independent level; no multi-bit coherence is needed.
module spis_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spis_tx_shift.sv
// Module: spis_tx_shift
// Builds the outgoing frame (data MSB first, optional parity bit) and shifts
// it onto the serial output one bit per launch request.
// Assumes: load and launch are never requested in the same cycle unless
// launch_now accompanies load; the configuration is static during a frame.
module spis_tx_shift #(
    parameter int MAX_W = 16,
    parameter int LW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             launch_now,
    input  logic             launch,
    input  logic [LW-1:0]    len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [MAX_W-1:0] word,
    output logic             sdo
);
    localparam int FW = MAX_W + 1;

    logic [MAX_W-1:0] data_m;
    logic             par_bit;
    logic [FW-1:0]    raw_v;
    logic [FW-1:0]    frame;
    logic [FW-1:0]    sh_q;
    int unsigned      nbits;

    // Mask the word, compute parity and left-align the frame.
    always_comb begin
        data_m  = word & ~({MAX_W{1'b1}} << len);
        par_bit = (^data_m) ^ par_odd;
        raw_v   = par_en ? {data_m, par_bit} : {1'b0, data_m};
        nbits   = int'(len) + int'(par_en);
        frame   = raw_v << (FW - nbits);
    end

    // Hold the remaining frame bits and the driven output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            sdo  <= 1'b0;
        end else if (load && launch_now) begin
            sdo  <= frame[FW-1];
            sh_q <= frame << 1;
        end else if (load) begin
            sh_q <= frame;
        end else if (launch) begin
            sdo  <= sh_q[FW-1];
            sh_q <= sh_q << 1;
        end
    end
endmodule

// File: rtl/spis_rx_shift.sv
// Module: spis_rx_shift
// Collects captured bits, and when the last bit of a word arrives publishes
// the right-aligned word, a one-cycle valid strobe and a gated parity event.
// Assumes: done is only asserted together with cap.
module spis_rx_shift #(
    parameter int MAX_W = 16,
    parameter int LW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic             cap,
    input  logic             done,
    input  logic [LW-1:0]    len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             par_ie,
    output logic [MAX_W-1:0] rx_word,
    output logic             rx_valid,
    output logic             par_err
);
    localparam int FW = MAX_W + 1;

    logic [FW-1:0]    sh_q;
    logic [FW-1:0]    nxt;
    logic [MAX_W-1:0] word_m;
    logic             mismatch;

    // Form the word including the bit arriving now, and test its parity.
    always_comb begin
        nxt      = {sh_q[FW-2:0], sdi};
        word_m   = (par_en ? nxt[FW-1:1] : nxt[FW-2:0]) & ~({MAX_W{1'b1}} << len);
        mismatch = par_en && (((^word_m) ^ nxt[0]) != par_odd);
    end

    // Shift in captured bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   sh_q <= '0;
        else if (cap) sh_q <= nxt;
    end

    // Publish a completed word with its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            rx_valid <= done;
            par_err  <= done && mismatch && par_ie;
            if (done) rx_word <= word_m;
        end
    end
endmodule

// File: rtl/spi_phase_slave.sv
// Module: spi_phase_slave (top)
// Serial slave shift unit: synchronizes the pins, detects edges, picks the
// launch and capture edges for the selected phase mode, counts bits per word
// and drives the transmit and receive shifters.
// Assumes: shift clock idles low; each shift clock level lasts at least four
// system clocks; configuration inputs are stable while select is high.
module spi_phase_slave #(
    parameter int MAX_W = 16,
    parameter int LW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             sel_i,
    input  logic             sdi_i,
    input  logic             phase_i,
    input  logic [LW-1:0]    word_len_i,
    input  logic             par_en_i,
    input  logic             par_odd_i,
    input  logic             par_ie_i,
    input  logic             sel_ie_i,
    input  logic [MAX_W-1:0] tx_word_i,
    output logic             sdo_o,
    output logic [MAX_W-1:0] rx_word_o,
    output logic             rx_valid_o,
    output logic             par_err_o,
    output logic             sel_evt_o
);
    import spis_pkg::*;

    localparam int CW = $clog2(MAX_W + 2);

    logic [2:0]    pins_s;
    logic          sck_s, sel_s, sdi_s;
    logic          sck_d, sel_d;
    logic          sck_rise, sck_fall, sel_rise, sel_fall;
    logic          cap_ev, launch_ev, word_done;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;
    phase_e        mode;

    spis_sync #(.N(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sck_i, sel_i, sdi_i}),
        .sync_o (pins_s)
    );

    assign sck_s = pins_s[2];
    assign sel_s = pins_s[1];
    assign sdi_s = pins_s[0];

    // Delay the synchronized clock and select by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            sel_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
            sel_d <= sel_s;
        end
    end

    // Decode edges, then the capture/launch events for the current mode.
    always_comb begin
        mode      = phase_e'(phase_i);
        sck_rise  = sck_s & ~sck_d;
        sck_fall  = ~sck_s & sck_d;
        sel_rise  = sel_s & ~sel_d;
        sel_fall  = ~sel_s & sel_d;
        cap_ev    = sel_s && ((mode == PH_SEL_LAUNCH) ? sck_rise : sck_fall);
        launch_ev = sel_s && ((mode == PH_SEL_LAUNCH) ? sck_fall : sck_rise);
        last_idx  = CW'(word_len_i) + CW'(par_en_i) - CW'(1);
        word_done = cap_ev && (cnt_q == last_idx);
    end

    // Count captured bits within a word; restart on any select change.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (sel_rise || sel_fall) cnt_q <= '0;
        else if (word_done)            cnt_q <= '0;
        else if (cap_ev)               cnt_q <= cnt_q + CW'(1);
    end

    // Raise the select activation event when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_evt_o <= 1'b0;
        else        sel_evt_o <= sel_rise && sel_ie_i;
    end

    spis_tx_shift #(.MAX_W(MAX_W), .LW(LW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sel_rise || word_done),
        .launch_now(sel_rise && (mode == PH_SEL_LAUNCH)),
        .launch    (launch_ev),
        .len       (word_len_i),
        .par_en    (par_en_i),
        .par_odd   (par_odd_i),
        .word      (tx_word_i),
        .sdo       (sdo_o)
    );

    spis_rx_shift #(.MAX_W(MAX_W), .LW(LW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdi     (sdi_s),
        .cap     (cap_ev),
        .done    (word_done),
        .len     (word_len_i),
        .par_en  (par_en_i),
        .par_odd (par_odd_i),
        .par_ie  (par_ie_i),
        .rx_word (rx_word_o),
        .rx_valid(rx_valid_o),
        .par_err (par_err_o)
    );
endmodule

// File: rtl/spi_phase_slave_chk.sv
// Module: spi_phase_slave_chk
// Temporal checks on the slave shift unit, attached by bind.
// Assumes: the same clock and reset as the checked instance.
module spi_phase_slave_chk #(
    parameter int MAX_W = 16,
    parameter int CW    = $clog2(MAX_W + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          par_err,
    input logic          sel_evt,
    input logic          par_ie,
    input logic          par_en,
    input logic          sel_ie,
    input logic          sel_lvl,
    input logic          sck_rise,
    input logic          sck_fall,
    input logic          phase,
    input logic [CW-1:0] cnt
);
    assert_valid_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_perr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (rx_valid && par_ie && par_en));

    assert_selevt_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_evt |-> sel_ie);

    assert_selevt_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_evt |=> !sel_evt);

    assert_no_valid_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sel_lvl));

    assert_capture_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(phase ? sck_rise : sck_fall));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_W));
endmodule

bind spi_phase_slave spi_phase_slave_chk #(.MAX_W(MAX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid_o),
    .par_err (par_err_o),
    .sel_evt (sel_evt_o),
    .par_ie  (par_ie_i),
    .par_en  (par_en_i),
    .sel_ie  (sel_ie_i),
    .sel_lvl (sel_s),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .phase   (phase_i),
    .cnt     (cnt_q)
);

// File: tb/spi_phase_slave_tb.sv
// Bench: drives the slave as a serial master, with seeded random frames plus
// directed corner cases, and compares against bench-computed expectations.
module spi_phase_slave_tb;
    localparam int MAX_W = 16;
    localparam int LW    = $clog2(MAX_W + 1);
    localparam int H     = 8;   // system clocks per shift clock half period

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sck_i = 1'b0, sel_i = 1'b0, sdi_i = 1'b0;
    logic             phase_i = 1'b0;
    logic [LW-1:0]    word_len_i = LW'(8);
    logic             par_en_i = 1'b0, par_odd_i = 1'b0;
    logic             par_ie_i = 1'b0, sel_ie_i = 1'b0;
    logic [MAX_W-1:0] tx_word_i = '0;
    logic             sdo_o;
    logic [MAX_W-1:0] rx_word_o;
    logic             rx_valid_o, par_err_o, sel_evt_o;

    int n_chk = 0, n_bad = 0;
    int n_valid = 0, n_perr = 0, n_sel = 0;
    logic [MAX_W-1:0] last_rx = '0;

    logic [MAX_W-1:0] txw [5];
    logic [MAX_W-1:0] mow [4];
    logic             flp [4];

    always #2 clk = ~clk;   // 250 MHz

    spi_phase_slave #(.MAX_W(MAX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sel_i(sel_i), .sdi_i(sdi_i),
        .phase_i(phase_i), .word_len_i(word_len_i), .par_en_i(par_en_i),
        .par_odd_i(par_odd_i), .par_ie_i(par_ie_i), .sel_ie_i(sel_ie_i),
        .tx_word_i(tx_word_i), .sdo_o(sdo_o), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o), .par_err_o(par_err_o), .sel_evt_o(sel_evt_o)
    );

    // Count output strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid_o) begin
                n_valid++;
                last_rx = rx_word_o;
            end
            if (par_err_o) n_perr++;
            if (sel_evt_o) n_sel++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [MAX_W-1:0] msk(input logic [MAX_W-1:0] w, input int len);
        return w & ~({MAX_W{1'b1}} << len);
    endfunction

    function automatic logic par_of(input logic [MAX_W-1:0] w, input int len, input logic odd);
        return (^msk(w, len)) ^ odd;
    endfunction

    // Frame bit i of word w: data MSB first, then the parity bit.
    function automatic logic fbit(input logic [MAX_W-1:0] w, input int len,
                                  input logic odd, input int i);
        if (i < len) return w[len-1-i];
        return par_of(w, len, odd);
    endfunction

    // One frame of nw words; abort_at >= 0 drops select after that many bits.
    task automatic run_frame(input logic mode, input int len, input logic pen,
                             input logic odd, input logic pie, input logic sie,
                             input int nw, input int abort_at);
        int nb, s0, v0, p0;
        logic mb, eb;
        string tg;
        phase_i = mode; word_len_i = LW'(len); par_en_i = pen; par_odd_i = odd;
        par_ie_i = pie; sel_ie_i = sie;
        tx_word_i = txw[0];
        wt(2);
        s0 = n_sel;
        sel_i = 1'b1;
        wt(H);
        chk("R8 select event", n_sel - s0, int'(sie));
        tx_word_i = txw[1];
        nb = len + int'(pen);
        for (int w = 0; w < nw; w++) begin
            v0 = n_valid; p0 = n_perr;
            for (int i = 0; i < nb; i++) begin
                if (abort_at >= 0 && i == abort_at) begin
                    sel_i = 1'b0;
                    wt(H);
                    chk("R9 aborted word gives no strobe", n_valid - v0, 0);
                    sck_i = 1'b0;
                    return;
                end
                mb = fbit(mow[w], len, odd, i) ^ (flp[w] && pen && i == len);
                eb = fbit(txw[w], len, odd, i);
                if (i == len)               tg = "R6 parity bit out";
                else if (w > 0 && i == 0)   tg = "R10 reloaded word";
                else if (mode && i == 0)    tg = "R3 first bit at select";
                else if (mode)              tg = "R4 trailing launch";
                else                        tg = "R1 leading launch";
                if (!mode) begin
                    sck_i = 1'b1; sdi_i = mb; wt(H);
                    chk(tg, sdo_o, eb);
                    sck_i = 1'b0; wt(H);
                end else begin
                    sdi_i = mb; wt(H);
                    chk(tg, sdo_o, eb);
                    sck_i = 1'b1; wt(H);
                    sck_i = 1'b0; wt(H);
                end
            end
            chk("R10 one strobe per word", n_valid - v0, 1);
            chk(mode ? "R4/R5 received word" : "R2/R5 received word",
                last_rx, msk(mow[w], len));
            chk("R7 parity event", n_perr - p0, int'(pen && flp[w] && pie));
            tx_word_i = txw[w+2];
        end
        sel_i = 1'b0;
        wt(H);
    endtask

    task automatic fill(input int nw, input logic fl);
        for (int k = 0; k < 5; k++) txw[k] = MAX_W'($urandom);
        for (int k = 0; k < 4; k++) begin
            mow[k] = MAX_W'($urandom);
            flp[k] = (k < nw) ? fl : 1'b0;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        wt(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset sdo", sdo_o, 0);
        chk("R11 reset word", rx_word_o, 0);
        chk("R11 reset strobes", {rx_valid_o, par_err_o, sel_evt_o}, 0);

        // Directed: full width, even parity, three words, leading-launch.
        fill(3, 1'b0); run_frame(1'b0, 16, 1'b1, 1'b0, 1'b1, 1'b1, 3, -1);
        // Directed: single-bit words, odd parity, corrupted, select-launch.
        fill(2, 1'b1); run_frame(1'b1, 1, 1'b1, 1'b1, 1'b1, 1'b0, 2, -1);
        // Directed: corrupted parity with the event disabled.
        fill(1, 1'b1); run_frame(1'b1, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1, -1);
        // Directed: aborts mid-word, then fresh frames must start clean.
        fill(1, 1'b0); run_frame(1'b0, 12, 1'b0, 1'b0, 1'b0, 1'b1, 1, 5);
        fill(1, 1'b0); run_frame(1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b1, 1, -1);
        fill(1, 1'b0); run_frame(1'b1, 9, 1'b1, 1'b1, 1'b1, 1'b0, 1, 3);
        fill(2, 1'b0); run_frame(1'b1, 9, 1'b1, 1'b1, 1'b1, 1'b0, 2, -1);

        // Seeded random frames.
        for (int f = 0; f < 24; f++) begin
            fill(1 + int'($urandom_range(2)), 1'($urandom));
            run_frame(1'($urandom), 1 + int'($urandom_range(MAX_W - 1)),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1 + int'($urandom_range(2)), -1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule